// File: doc/BRIEF.md
# SPI Potentiometer Register Slave

This block is the serial front end of a digital potentiometer. It lets a host reach a small register set over a mode-0 SPI link: chip select active low, data captured on rising SCK and launched on falling SCK, most significant bit first. The three link pins are brought into the system clock domain and oversampled, so the whole block runs on one clock. Every access is a fixed three-byte frame. A signature byte comes first, then a command byte that carries a 4-bit opcode and a 2-bit register pointer, then a data byte.

A write frame is not acted on while it is still in flight. When chip select rises after exactly 24 bits, the block emits a one-cycle strobe together with the pointer and the data byte, and the register controller commits the value. In a read frame, the block asks the controller for the addressed register when the command byte completes. It then shifts that value out during the third byte through an open-drain pin, given as a data bit plus an output enable. A frame whose signature, opcode, pointer or length is wrong has no effect at all.

Top module: `spi_pot_slave`

## Requirements
- R1: SDI is captured on rising SCK edges, MSB first. The data byte of a write arrives on reg_wr_data with its bit order preserved, and reg_wr_ptr carries the command byte's bits 1:0.
- R2: The first byte must equal 8'h50. With any other value, the frame produces no write strobe and no SDO drive.
- R3: Bits 7:4 of the command byte select the operation: 4'b1100 is a write and 4'b1011 is a read. Any other opcode produces no strobe and no SDO drive.
- R4: Bits 3:2 of the command byte must be 00. Bits 1:0 must be 00 (wiper location) or 10 (control register). Pointers 01 and 11 and non-zero bits 3:2 make the frame void.
- R5: A valid write produces exactly one single-cycle reg_wr_stb, and only after chip select rises. No strobe appears while the frame is in progress.
- R6: A frame is valid only when exactly 24 rising SCK edges occur between the chip-select fall and the chip-select rise. A shorter or longer frame produces no strobe.
- R7: In a valid read, bit 7 of the returned value is presented after the falling edge that follows the 16th rising edge. The remaining bits follow MSB first, one per falling edge. spi_sdo_oe is high exactly when the current bit is 0, and it drops after the falling edge that follows the 24th rising edge.
- R8: A read of pointer 00 returns bit 7 as 0 whatever reg_rd_data[7] holds. A read of pointer 10 returns all 8 bits of reg_rd_data.
- R9: After reset, and while chip select is high, spi_sdo_oe is low and the bit count restarts on the next chip-select fall.
- R10: A frame is accepted only after a high-to-low chip-select edge. If chip select is low when reset is released, bits clocked before a fresh high-to-low edge are ignored.
- R11: A read frame never produces a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data from the host |
| spi_sdo_o | output | 1 | Current outgoing bit; 1 when idle |
| spi_sdo_oe | output | 1 | Open-drain enable; when high the pad pulls SDO low |
| reg_wr_stb | output | 1 | One-cycle write commit strobe |
| reg_wr_ptr | output | 2 | Register pointer of the committed write |
| reg_wr_data | output | 8 | Data byte of the committed write |
| reg_rd_ptr | output | 2 | Pointer of the read in progress |
| reg_rd_data | input | 8 | Register value returned by the controller for reg_rd_ptr |

## Verification
The bench goes after the frame-length boundaries. A block that counts loosely would commit a 23-bit or 25-bit write, or would commit in the middle of a frame instead of at the chip-select rise. Single-bit corruptions of the signature byte and every illegal opcode or pointer are sent. A decoder that checks only some bits would strobe on them. Reads of the wiper location are made while the controller's bit 7 is set, so a block that failed to force the leading 0 would return a wrong value. The bench also watches the SDO enable outside the read data phase and holds chip select low across reset, which catches a block that arms without a falling edge.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int CNT_SAT     = FRAME_BITS + 1;
    localparam int CNT_W       = $clog2(CNT_SAT + 1);

    localparam logic [BYTE_W-1:0] SIG_BYTE = 8'h50;
    localparam logic [3:0] OPC_READ  = 4'b1011;
    localparam logic [3:0] OPC_WRITE = 4'b1100;
    localparam logic [1:0] PTR_WIPER = 2'b00;
    localparam logic [1:0] PTR_CTRL  = 2'b10;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

    function automatic cmd_e decode_hdr(input logic [BYTE_W-1:0] hdr);
        cmd_e c;
        c = CMD_NONE;
        if (hdr[3:2] == 2'b00 && (hdr[1:0] == PTR_WIPER || hdr[1:0] == PTR_CTRL)) begin
            if (hdr[7:4] == OPC_READ)       c = CMD_RD;
            else if (hdr[7:4] == OPC_WRITE) c = CMD_WR;
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign dout[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/spi_pot_frame.sv
module spi_pot_frame
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              sdi_s,
    output logic              cs_act,
    output logic              sck_fall,
    output logic              rd_load,
    output logic [1:0]        rd_ptr,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              wr_stb,
    output logic [1:0]        wr_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] CNT_SIG_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(2 * BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_TOP      = CNT_W'(CNT_SAT);
    localparam logic [CNT_W-1:0] CNT_RDSTART  = CNT_W'(2 * BYTE_W);

    typedef struct packed {
        logic              sck_prev;
        logic              csn_prev;
        logic              armed;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              sig_ok;
        cmd_e              cmd;
        logic [1:0]        ptr;
        logic              rd_load;
        logic              sck_fall;
        logic              wr_stb;
        logic [1:0]        wr_ptr;
        logic [BYTE_W-1:0] wr_data;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        logic              sck_rise;
        logic              sck_drop;
        logic              cs_rise;
        logic              cs_fall;
        logic [BYTE_W-1:0] sh_n;
        cmd_e              cmd_n;

        sck_rise = sck_s & ~fr_q.sck_prev;
        sck_drop = ~sck_s & fr_q.sck_prev;
        cs_rise  = csn_s & ~fr_q.csn_prev;
        cs_fall  = ~csn_s & fr_q.csn_prev;
        sh_n     = {fr_q.sh[BYTE_W-2:0], sdi_s};
        cmd_n    = decode_hdr(sh_n);

        fr_d          = fr_q;
        fr_d.sck_prev = sck_s;
        fr_d.csn_prev = csn_s;
        fr_d.rd_load  = 1'b0;
        fr_d.sck_fall = 1'b0;
        fr_d.wr_stb   = 1'b0;

        if (cs_rise) begin
            if (fr_q.armed && fr_q.cnt == CNT_FULL && fr_q.sig_ok && fr_q.cmd == CMD_WR) begin
                fr_d.wr_stb  = 1'b1;
                fr_d.wr_ptr  = fr_q.ptr;
                fr_d.wr_data = fr_q.sh;
            end
            fr_d.armed  = 1'b0;
            fr_d.cnt    = '0;
            fr_d.sig_ok = 1'b0;
            fr_d.cmd    = CMD_NONE;
        end else if (cs_fall) begin
            fr_d.armed  = 1'b1;
            fr_d.cnt    = '0;
            fr_d.sig_ok = 1'b0;
            fr_d.cmd    = CMD_NONE;
        end else if (fr_q.armed && !csn_s) begin
            if (sck_rise) begin
                fr_d.sh = sh_n;
                if (fr_q.cnt != CNT_TOP) fr_d.cnt = fr_q.cnt + 1'b1;
                if (fr_q.cnt == CNT_SIG_LAST) fr_d.sig_ok = (sh_n == SIG_BYTE);
                if (fr_q.cnt == CNT_HDR_LAST) begin
                    fr_d.cmd     = fr_q.sig_ok ? cmd_n : CMD_NONE;
                    fr_d.ptr     = sh_n[1:0];
                    fr_d.rd_load = fr_q.sig_ok && (cmd_n == CMD_RD);
                end
            end
            fr_d.sck_fall = sck_drop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q          <= '0;
            fr_q.cmd      <= CMD_NONE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign cs_act   = fr_q.armed;
    assign sck_fall = fr_q.sck_fall;
    assign rd_load  = fr_q.rd_load;
    assign rd_ptr   = fr_q.ptr;
    assign bit_cnt  = fr_q.cnt;
    assign wr_stb   = fr_q.wr_stb;
    assign wr_ptr   = fr_q.wr_ptr;
    assign wr_data  = fr_q.wr_data;

    assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    assert_strobe_after_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !cs_act);
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_TOP);
    assert_idle_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> bit_cnt == '0);
    assert_rdload_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |-> (cs_act && bit_cnt == CNT_RDSTART));
endmodule

// File: rtl/spi_pot_sdo.sv
module spi_pot_sdo
    import spi_pot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_fall,
    input  logic              rd_load,
    input  logic [1:0]        rd_ptr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  bit_cnt,
    output logic              sdo_o,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] CNT_RDSTART = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] CNT_FULL    = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [BYTE_W-1:0] shadow;
        logic              active;
        logic              bit_out;
        logic              oe;
    } sdo_t;

    sdo_t so_d, so_q;

    always_comb begin
        so_d = so_q;
        if (!cs_act) begin
            so_d.active  = 1'b0;
            so_d.oe      = 1'b0;
            so_d.bit_out = 1'b1;
        end else if (rd_load) begin
            so_d.shadow = (rd_ptr == PTR_WIPER) ? {1'b0, rd_data[BYTE_W-2:0]} : rd_data;
            so_d.active = 1'b1;
        end else if (sck_fall && so_q.active) begin
            if (bit_cnt >= CNT_RDSTART && bit_cnt < CNT_FULL) begin
                so_d.bit_out = so_q.shadow[BYTE_W-1];
                so_d.oe      = ~so_q.shadow[BYTE_W-1];
                so_d.shadow  = {so_q.shadow[BYTE_W-2:0], 1'b0};
            end else if (bit_cnt >= CNT_FULL) begin
                so_d.active  = 1'b0;
                so_d.oe      = 1'b0;
                so_d.bit_out = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q         <= '0;
            so_q.bit_out <= 1'b1;
        end else begin
            so_q <= so_d;
        end
    end

    assign sdo_o  = so_q.bit_out;
    assign sdo_oe = so_q.oe;

    assert_od_low_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !sdo_o);
    assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);
    assert_drive_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (bit_cnt >= CNT_RDSTART));
endmodule

// File: rtl/spi_pot_slave.sv
module spi_pot_slave
    import spi_pot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    output logic              spi_sdo_o,
    output logic              spi_sdo_oe,
    output logic              reg_wr_stb,
    output logic [1:0]        reg_wr_ptr,
    output logic [BYTE_W-1:0] reg_wr_data,
    output logic [1:0]        reg_rd_ptr,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    logic [2:0]       pins_s;
    logic             cs_act;
    logic             sck_fall;
    logic             rd_load;
    logic [CNT_W-1:0] bit_cnt;

    spi_pot_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sck, spi_csn, spi_sdi}),
        .dout  (pins_s)
    );

    spi_pot_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (pins_s[2]),
        .csn_s    (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .cs_act   (cs_act),
        .sck_fall (sck_fall),
        .rd_load  (rd_load),
        .rd_ptr   (reg_rd_ptr),
        .bit_cnt  (bit_cnt),
        .wr_stb   (reg_wr_stb),
        .wr_ptr   (reg_wr_ptr),
        .wr_data  (reg_wr_data)
    );

    spi_pot_sdo u_sdo (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_fall (sck_fall),
        .rd_load  (rd_load),
        .rd_ptr   (reg_rd_ptr),
        .rd_data  (reg_rd_data),
        .bit_cnt  (bit_cnt),
        .sdo_o    (spi_sdo_o),
        .sdo_oe   (spi_sdo_oe)
    );
endmodule

// File: tb/tb_spi_pot_slave.sv
module tb_spi_pot_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       csn = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo_o, sdo_oe, wr_stb;
    logic [1:0] wr_ptr, rd_ptr;
    logic [7:0] wr_data, rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    logic [1:0] last_ptr = 2'b00;
    logic [7:0] last_data = 8'h00;
    logic [6:0] m_wiper = 7'h40;
    logic [7:0] m_ctrl = 8'h40;

    always #2.5 clk = ~clk;

    wire sdo_line = sdo_oe ? 1'b0 : 1'b1;

    spi_pot_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_sdi(sdi),
        .spi_sdo_o(sdo_o), .spi_sdo_oe(sdo_oe), .reg_wr_stb(wr_stb),
        .reg_wr_ptr(wr_ptr), .reg_wr_data(wr_data), .reg_rd_ptr(rd_ptr),
        .reg_rd_data(rd_data)
    );

    // register controller model; wiper bit 7 reads back as 1 to expose masking
    always_comb begin
        if (rd_ptr == 2'b00)      rd_data = {1'b1, m_wiper};
        else if (rd_ptr == 2'b10) rd_data = m_ctrl;
        else                      rd_data = 8'h3C;
    end

    always @(posedge clk) begin
        if (wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_ptr  <= wr_ptr;
            last_data <= wr_data;
            if (wr_ptr == 2'b00) m_wiper <= wr_data[6:0];
            else                 m_ctrl  <= wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // 0 = void, 1 = read, 2 = write
    function automatic int hdr_kind(input logic [7:0] b0, input logic [7:0] b1);
        if (b0 != 8'h50) return 0;
        if (b1[3:2] != 2'b00) return 0;
        if (!(b1[1:0] == 2'b00 || b1[1:0] == 2'b10)) return 0;
        if (b1[7:4] == 4'b1011) return 1;
        if (b1[7:4] == 4'b1100) return 2;
        return 0;
    endfunction

    task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                             input int nbits, input bit do_fall, input bit armed, input string req);
        int kind;
        int s0;
        bit bad_oe;
        logic [7:0] got;
        logic [7:0] exp_rd;
        logic [23:0] fr;
        kind   = armed ? hdr_kind(b0, b1) : 0;
        s0     = stb_cnt;
        bad_oe = 1'b0;
        got    = 8'h00;
        fr     = {b0, b1, b2};
        exp_rd = (b1[1:0] == 2'b00) ? {1'b0, m_wiper} : m_ctrl;
        @(negedge clk);
        if (do_fall) csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            sdi = (k < 24) ? fr[23-k] : 1'($urandom);
            repeat (HALF) @(negedge clk);
            if (k >= 16 && k < 24) got[23-k] = sdo_line;
            if (sdo_oe && !(kind == 1 && k >= 16 && k < 24)) bad_oe = 1'b1;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (sdo_oe && !(kind == 1 && nbits < 24)) bad_oe = 1'b1;
        chk(stb_cnt == s0, "R5", "strobe before cs rise", stb_cnt - s0, 0);
        chk(!bad_oe, "R7", "sdo driven outside read phase", bad_oe, 0);
        csn = 1'b1;
        repeat (12) @(negedge clk);
        chk(!sdo_oe, "R9", "sdo released with cs high", sdo_oe, 0);
        if (kind == 2 && nbits == 24) begin
            chk(stb_cnt == s0 + 1, req, "write strobe count", stb_cnt - s0, 1);
            chk(last_ptr == b1[1:0] && last_data == b2, "R1", "write ptr/data",
                {22'd0, last_ptr, last_data}, {22'd0, b1[1:0], b2});
        end else begin
            chk(stb_cnt == s0, req, "void/read frame strobe count", stb_cnt - s0, 0);
        end
        if (kind == 1 && nbits >= 24)
            chk(got == exp_rd, req, "read data on sdo", got, exp_rd);
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        logic [7:0] b0, b1, b2;
        int nb;
        void'($urandom(32'd20231));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sdo_oe == 1'b0, "R9", "reset sdo_oe", sdo_oe, 0);
        chk(stb_cnt == 0, "R9", "reset strobe", stb_cnt, 0);

        // cs held low through reset: not armed
        run_frame(8'h50, 8'hC2, 8'h11, 24, 1'b0, 1'b0, "R10");

        run_frame(8'h50, 8'hC2, 8'h40, 24, 1'b1, 1'b1, "R5");
        run_frame(8'h50, 8'hC0, 8'h77, 24, 1'b1, 1'b1, "R1");
        run_frame(8'h50, 8'hB0, 8'h00, 24, 1'b1, 1'b1, "R8");
        run_frame(8'h50, 8'hB2, 8'hFF, 24, 1'b1, 1'b1, "R8");
        run_frame(8'h50, 8'hC0, 8'h2A, 24, 1'b1, 1'b1, "R1");
        run_frame(8'h50, 8'hB0, 8'h5A, 24, 1'b1, 1'b1, "R11");
        run_frame(8'h51, 8'hC2, 8'h99, 24, 1'b1, 1'b1, "R2");
        run_frame(8'hD0, 8'hB2, 8'h00, 24, 1'b1, 1'b1, "R2");
        run_frame(8'h50, 8'hA2, 8'h99, 24, 1'b1, 1'b1, "R3");
        run_frame(8'h50, 8'h32, 8'h00, 24, 1'b1, 1'b1, "R3");
        run_frame(8'h50, 8'hC1, 8'h99, 24, 1'b1, 1'b1, "R4");
        run_frame(8'h50, 8'hC6, 8'h99, 24, 1'b1, 1'b1, "R4");
        run_frame(8'h50, 8'hB3, 8'h00, 24, 1'b1, 1'b1, "R4");
        run_frame(8'h50, 8'hC2, 8'h99, 23, 1'b1, 1'b1, "R6");
        run_frame(8'h50, 8'hC2, 8'h99, 25, 1'b1, 1'b1, "R6");
        run_frame(8'h50, 8'hB2, 8'h00, 24, 1'b1, 1'b1, "R7");

        for (int i = 0; i < 40; i++) begin
            int sel;
            sel = $urandom % 8;
            b0 = 8'h50;
            b1 = ($urandom % 2) ? 8'hC0 : 8'hB0;
            b1[1] = 1'($urandom);
            b2 = 8'($urandom);
            nb = 24;
            if (sel == 3) b0 = 8'h50 ^ (8'h01 << ($urandom % 8));
            if (sel == 4) b1[7:4] = 4'($urandom);
            if (sel == 5) b1[3:0] = 4'($urandom);
            if (sel == 6) nb = 8 + ($urandom % 16);
            if (sel == 7) nb = 25 + ($urandom % 6);
            run_frame(b0, b1, b2, nb, 1'b1, 1'b1, "R6");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule